// File: doc/BRIEF.md
# Paged Program Counter Sequencer

This block holds the instruction fetch address of a small 8-bit controller whose instructions are 14 bits wide. Each cycle it moves the program counter in one of several ways: one step forward, an absolute jump or subroutine call whose target field is narrower than the counter, a computed jump made by writing the low byte of the counter from the data bus, or a return that restores a saved address from a dedicated hardware stack.

Transfers that carry too few address bits fill in the upper bits from a 5-bit high-address latch. Software loads the latch from the data bus with its own strobe, and no other event changes it. The return stack has a fixed depth of eight. Only call and return reach it. It works as a ring, so overflow and underflow wrap around without any indication.

Each cycle the controls are resolved into one operation, which is treated as the current state of the sequencer: `OP_HOLD`, `OP_STEP`, `OP_PCLW`, `OP_JUMP`, `OP_CALL` and `OP_RET`. Any operation may follow any other on the next cycle. The transition is chosen by fixed priority: RET over CALL over JUMP over PCLW over STEP, and HOLD when no strobe is active.

Top module: `pc_sequencer`

## Requirements
- R1: While reset is asserted and right after it, the fetch address is 0x0000, the latch reads 0 and every stack entry holds 0. A return issued straight after reset therefore goes to 0x0000.
- R2: On a step, the fetch address becomes the old address plus one, taken modulo 8192, so 0x1FFF is followed by 0x0000.
- R3: On a jump, fetch bits [10:0] take the 11-bit immediate and bits [12:11] take latch bits [4:3]. The latch value used is the one held before that clock edge.
- R4: A call loads the same target as a jump. It also pushes the old fetch address plus one, modulo 8192, onto the return stack.
- R5: A return loads the full 13-bit fetch address from the most recent stack entry and removes that entry. The latch plays no part in it.
- R6: A low-byte write sets fetch bits [7:0] to the data bus and bits [12:8] to latch bits [4:0], using the latch value held before that clock edge.
- R7: A latch write stores data bus bits [4:0], and the new value shows on the latch readback one cycle later. The latch changes on nothing else: jumps, calls and returns leave it alone. A latch write and a PC transfer in the same cycle are both performed.
- R8: The stack is a ring of 8 entries. The ninth push without a pop overwrites the oldest entry. Pops beyond the stored entries keep wrapping round the ring. No flag is raised in either case.
- R9: When several PC strobes are active, exactly one operation is taken, by the priority return > call > jump > low-byte write > step. With no PC strobe active the fetch address holds.
- R10: The low-byte readback always equals fetch address bits [7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Advance to the next sequential address |
| jump_i | input | 1 | Absolute jump to the immediate target |
| call_i | input | 1 | Subroutine call to the immediate target |
| ret_i | input | 1 | Return to the address on top of the stack |
| pcl_wr_i | input | 1 | Computed jump: write the low byte of the PC |
| lath_wr_i | input | 1 | Load the high-address latch |
| imm_i | input | 11 | Target field of a jump or call |
| data_i | input | 8 | Data bus, for low-byte and latch writes |
| fetch_addr_o | output | 13 | Current instruction fetch address |
| pcl_o | output | 8 | Readback of the low PC byte |
| lath_o | output | 5 | Readback of the high-address latch |

## Verification
A wrong next-address choice, such as a bad priority or wrong fill-in bits, shows on the fetch address on the very next cycle. A corrupted latch can stay hidden until the next jump or low-byte write, so the bench reads the latch back on every cycle. A slipped stack pointer or a lost push stays invisible until a return is made, possibly many calls later. Deep call runs that wrap the ring, followed by runs of returns, bring such errors out at the first affected return.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
    // One resolved operation per cycle, in ascending priority order.
    typedef enum logic [2:0] {
        OP_HOLD = 3'd0,
        OP_STEP = 3'd1,
        OP_PCLW = 3'd2,
        OP_JUMP = 3'd3,
        OP_CALL = 3'd4,
        OP_RET  = 3'd5
    } pc_op_e;
endpackage

// File: rtl/pcseq_arbiter.sv
module pcseq_arbiter
    import pcseq_pkg::*;
(
    input  logic   step_i,
    input  logic   jump_i,
    input  logic   call_i,
    input  logic   ret_i,
    input  logic   pclw_i,
    output pc_op_e op_o
);
    // R9: fixed priority, return first.
    always_comb begin
        if (ret_i)       op_o = OP_RET;
        else if (call_i) op_o = OP_CALL;
        else if (jump_i) op_o = OP_JUMP;
        else if (pclw_i) op_o = OP_PCLW;
        else if (step_i) op_o = OP_STEP;
        else             op_o = OP_HOLD;
    end
endmodule

// File: rtl/pcseq_latch.sv
module pcseq_latch #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q_o <= '0;
        else if (wr_i) q_o <= d_i;
    end

    // R7: only an explicit write changes the latch
    a_r7_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(q_o));
    a_r7_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> q_o == $past(d_i));
endmodule

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] push_data_i,
    output logic [W-1:0] top_o
);
    localparam int SP_W = $clog2(DEPTH);
    localparam logic [SP_W-1:0] SP_ONE = SP_W'(1);

    logic [SP_W-1:0] sp_q;
    logic [SP_W-1:0] sp_top;
    logic [W-1:0]    mem_q [DEPTH];

    // Ring pointer: natural wrap gives overwrite and endless pops (R8)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sp_q <= '0;
        else if (push_i) sp_q <= sp_q + SP_ONE;
        else if (pop_i)  sp_q <= sp_q - SP_ONE;
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_entry
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    mem_q[g] <= '0;
                else if (push_i && (sp_q == SP_W'(g)))
                    mem_q[g] <= push_data_i;
            end
        end
    endgenerate

    assign sp_top = sp_q - SP_ONE;
    assign top_o  = mem_q[sp_top];

    // R8: pointer moves by exactly one per push or pop, wrapping
    a_r8_push_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> sp_q == $past(sp_q) + SP_ONE);
    a_r8_pop_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i) |=> sp_q == $past(sp_q) - SP_ONE);
    a_r9_no_push_pop: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && pop_i));
    a_r4_push_visible: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> top_o == $past(push_data_i));
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pcseq_pkg::*;
#(
    parameter int PC_W      = 13,
    parameter int JMP_W     = 11,
    parameter int DATA_W    = 8,
    parameter int STK_DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     step_i,
    input  logic                     jump_i,
    input  logic                     call_i,
    input  logic                     ret_i,
    input  logic                     pcl_wr_i,
    input  logic                     lath_wr_i,
    input  logic [JMP_W-1:0]         imm_i,
    input  logic [DATA_W-1:0]        data_i,
    output logic [PC_W-1:0]          fetch_addr_o,
    output logic [DATA_W-1:0]        pcl_o,
    output logic [PC_W-DATA_W-1:0]   lath_o
);
    localparam int LATH_W = PC_W - DATA_W;
    localparam int HI_W   = PC_W - JMP_W;
    localparam logic [PC_W-1:0] PC_ONE = PC_W'(1);

    pc_op_e            op;
    logic [PC_W-1:0]   pc_q;
    logic [PC_W-1:0]   pc_d;
    logic [PC_W-1:0]   pc_next_seq;
    logic [PC_W-1:0]   stk_top;
    logic [LATH_W-1:0] lath_q;

    pcseq_arbiter u_arb (
        .step_i (step_i),
        .jump_i (jump_i),
        .call_i (call_i),
        .ret_i  (ret_i),
        .pclw_i (pcl_wr_i),
        .op_o   (op)
    );

    pcseq_latch #(.W(LATH_W)) u_lath (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_i  (lath_wr_i),
        .d_i   (data_i[LATH_W-1:0]),
        .q_o   (lath_q)
    );

    assign pc_next_seq = pc_q + PC_ONE;

    pcseq_stack #(.DEPTH(STK_DEPTH), .W(PC_W)) u_stk (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (op == OP_CALL),
        .pop_i       (op == OP_RET),
        .push_data_i (pc_next_seq),
        .top_o       (stk_top)
    );

    // Next-address selection, one case per operation state
    always_comb begin
        pc_d = pc_q;
        unique case (op)
            OP_HOLD: pc_d = pc_q;
            OP_STEP: pc_d = pc_next_seq;
            OP_PCLW: pc_d = {lath_q, data_i};
            OP_JUMP: pc_d = {lath_q[LATH_W-1 -: HI_W], imm_i};
            OP_CALL: pc_d = {lath_q[LATH_W-1 -: HI_W], imm_i};
            OP_RET:  pc_d = stk_top;
            default: pc_d = pc_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    assign fetch_addr_o = pc_q;
    assign pcl_o        = pc_q[DATA_W-1:0];
    assign lath_o       = lath_q;

    // R2: a lone step advances by one with wrap
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !ret_i && !call_i && !jump_i && !pcl_wr_i)
        |=> fetch_addr_o == $past(fetch_addr_o) + PC_ONE);
    // R3: jump fills high bits from the latch held before the edge
    a_r3_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_i && !ret_i && !call_i)
        |=> fetch_addr_o == {$past(lath_o[LATH_W-1 -: HI_W]), $past(imm_i)});
    // R6: low-byte write fills the upper bits from the latch
    a_r6_pcl_write: assert property (@(posedge clk) disable iff (!rst_n)
        (pcl_wr_i && !ret_i && !call_i && !jump_i)
        |=> fetch_addr_o == {$past(lath_o), $past(data_i)});
    // R9: no strobe, no movement
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !ret_i && !call_i && !jump_i && !pcl_wr_i)
        |=> $stable(fetch_addr_o));
endmodule

// File: tb/pc_sequencer_tb.sv
module pc_sequencer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i = 0, jump_i = 0, call_i = 0, ret_i = 0, pcl_wr_i = 0, lath_wr_i = 0;
    logic [10:0] imm_i = '0;
    logic [7:0]  data_i = '0;
    logic [12:0] fetch_addr_o;
    logic [7:0]  pcl_o;
    logic [4:0]  lath_o;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    // bench model
    logic [12:0] m_pc = '0;
    logic [4:0]  m_lath = '0;
    logic [12:0] m_stk [8];
    logic [2:0]  m_sp = '0;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk; // 50 MHz

    pc_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .jump_i(jump_i),
        .call_i(call_i), .ret_i(ret_i), .pcl_wr_i(pcl_wr_i),
        .lath_wr_i(lath_wr_i), .imm_i(imm_i), .data_i(data_i),
        .fetch_addr_o(fetch_addr_o), .pcl_o(pcl_o), .lath_o(lath_o)
    );

    function automatic logic [15:0] nxt(logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    task automatic check13(string req, logic [12:0] act, logic [12:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, model the edge, check 5 ns after it.
    task automatic cyc(string req, bit st, bit jp, bit cl, bit rt, bit pw, bit lw,
                       logic [10:0] imm, logic [7:0] dat);
        logic [12:0] pc_old;
        @(negedge clk);
        step_i = st; jump_i = jp; call_i = cl; ret_i = rt;
        pcl_wr_i = pw; lath_wr_i = lw; imm_i = imm; data_i = dat;
        pc_old = m_pc;
        if (rt) begin
            m_sp = m_sp - 3'd1;
            m_pc = m_stk[m_sp];
        end else if (cl) begin
            m_stk[m_sp] = pc_old + 13'd1;
            m_sp = m_sp + 3'd1;
            m_pc = {m_lath[4:3], imm};
        end else if (jp) begin
            m_pc = {m_lath[4:3], imm};
        end else if (pw) begin
            m_pc = {m_lath, dat};
        end else if (st) begin
            m_pc = pc_old + 13'd1;
        end
        if (lw) m_lath = dat[4:0];
        @(posedge clk);
        #5;
        check13(req, fetch_addr_o, m_pc);
        check13("R10", {5'd0, pcl_o}, {5'd0, m_pc[7:0]});
        check13("R7", {8'd0, lath_o}, {8'd0, m_lath});
    endtask

    initial begin
        for (int i = 0; i < 8; i++) m_stk[i] = '0;
        #25;
        // R1: reset state
        check13("R1", fetch_addr_o, 13'd0);
        check13("R1", {8'd0, lath_o}, 13'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #15;
        check13("R1", fetch_addr_o, 13'd0);
        // R1: return right after reset lands on zero (stack cleared)
        cyc("R1", 0, 0, 0, 1, 0, 0, 11'h7FF, 8'hFF);
        cyc("R9", 0, 0, 0, 0, 0, 0, 11'h123, 8'h45);

        // R2: wrap from 0x1FFF to 0x0000 via a computed jump to 0x1FF8
        cyc("R7", 0, 0, 0, 0, 0, 1, 11'd0, 8'hFF);
        cyc("R6", 0, 0, 0, 0, 1, 0, 11'd0, 8'hF8);
        for (int i = 0; i < 12; i++) cyc("R2", 1, 0, 0, 0, 0, 0, 11'd0, 8'd0);

        // R3: every latch value with pseudo-random targets; R7 same-cycle write uses old latch
        for (int l = 0; l < 32; l++) begin
            lfsr = nxt(lfsr);
            cyc("R7", 0, 0, 0, 0, 0, 1, 11'd0, {3'b101, 5'(l)});
            cyc("R3", 0, 1, 0, 0, 0, 1, lfsr[10:0], 8'(lfsr[15:8]));
            cyc("R3", 0, 1, 0, 0, 0, 0, ~lfsr[10:0], 8'h00);
        end

        // R6: all low-byte values with a varying latch
        for (int d = 0; d < 256; d++) begin
            cyc("R7", 0, 0, 0, 0, 0, 1, 11'd0, 8'(d * 7));
            cyc("R6", 0, 0, 0, 0, 1, 0, 11'd0, 8'(d));
        end

        // R4/R5/R8: ten nested calls overflow the ring, twelve returns underflow it
        for (int k = 0; k < 10; k++) begin
            lfsr = nxt(lfsr);
            cyc("R4", 0, 0, 1, 0, 0, (k % 3) == 0, lfsr[10:0], 8'(k * 11));
            cyc("R2", 1, 0, 0, 0, 0, 0, 11'd0, 8'd0);
        end
        for (int k = 0; k < 12; k++) cyc("R8", 0, 0, 0, 1, 0, 0, 11'h555, 8'h2A);
        cyc("R5", 0, 0, 1, 0, 0, 0, 11'h3C3, 8'd0);
        cyc("R5", 0, 0, 0, 1, 0, 1, 11'd0, 8'h13);

        // R9: all 64 strobe combinations, four times with fresh operands
        for (int rep = 0; rep < 4; rep++) begin
            for (int c = 0; c < 64; c++) begin
                lfsr = nxt(lfsr);
                cyc("R9", c[0], c[1], c[2], c[3], c[4], c[5], lfsr[10:0], lfsr[15:8]);
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule